// File: doc/BRIEF.md
# Unified Data Space Address Decoder

This block sits between an 8-bit core's load/store unit and the storage behind its flat 16-bit byte address space. One data-space port carries an address, read and write strobes and a write byte. The block decides which of three windows the address falls into, performs the access, and returns read bytes on a registered output. The three windows are the general-purpose register file, a block of I/O registers and internal SRAM.

The register file and the SRAM are held inside the block. The register file also serves the core's ALU through its own combinational read port and its own write port. So a load or store that targets a low address acts on the same registers the ALU uses. The I/O window is passed outside through a narrow port. That port carries a local register index, strobes, the write byte and the returned read byte. Any address past the end of SRAM is a hole in the map.

Top module: `dspace_decoder`

## Requirements
- R1: Data-space byte addresses map as follows. 0x0000–0x001F select registers 0–31. 0x0020–0x005F select I/O registers. 0x0060–0x085F select the 2048 SRAM bytes, with SRAM byte k at address 0x0060 + k. Every higher address is unmapped.
- R2: `ds_rdata` changes only at a clock edge where `ds_rd` is high and `ds_wr` is low. On that edge it takes the byte at `ds_addr`. At every other edge it holds its value.
- R3: A data-space read of address n (n < 32) returns register n. Address 0x0000 returns register 0.
- R4: A data-space write to address n (n < 32) updates register n at that edge. The new value is visible on the ALU read port afterwards.
- R5: For an address A in the I/O window, `io_addr` equals A − 0x20. `io_rd` is high in the same cycle as a read-only strobe, and `io_wr` in the same cycle as a write strobe. On a write, `io_wdata` equals `ds_wdata`. Both I/O strobes stay low for any address outside the window.
- R6: A read of an I/O address returns the `io_rdata` value present during the strobe cycle.
- R7: A write to an SRAM address stores the byte, and a later read of that address returns it.
- R8: A read of an unmapped address returns 0x00. A write to one changes no register, no SRAM byte and no I/O strobe.
- R9: When `ds_rd` and `ds_wr` are high together, only the write takes place. `io_rd` stays low and `ds_rdata` holds.
- R10: When the data-space port and the ALU port write the same register in one cycle, the data-space byte is stored.
- R11: The ALU write port updates the register at the clock edge. `alu_rdata` shows register `alu_raddr` combinationally. A data-space read in the same cycle as an ALU write to that register returns the old value.
- R12: After reset, `ds_rdata` is 0x00 and all 32 registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ds_addr | input | 16 | Data-space byte address |
| ds_rd | input | 1 | Data-space read strobe |
| ds_wr | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write byte |
| ds_rdata | output | 8 | Registered read byte |
| alu_raddr | input | 5 | ALU register read index |
| alu_rdata | output | 8 | ALU register read byte (combinational) |
| alu_we | input | 1 | ALU register write enable |
| alu_waddr | input | 5 | ALU register write index |
| alu_wdata | input | 8 | ALU register write byte |
| io_addr | output | 6 | I/O register index |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte, valid in the strobe cycle |

## Verification
The assertions assume that `io_rdata` is a stable function of `io_addr` during a strobe cycle. They also assume the strobes are known and stable around each clock edge. The bench drives every input at the falling edge. It generates `io_rdata` combinationally from `io_addr`. It reads SRAM only at addresses it has already written, so every expected byte is defined. Random traffic mixes all four windows, overlapping strobes and colliding register writes under the same rules.

// File: rtl/dspace_pkg.sv
// Package: shared types and default sizes for the data-space decoder.
// Assumes a flat byte-addressed space with regions stacked from address 0.
package dspace_pkg;
    typedef enum logic [1:0] {
        RGN_GPR  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_SRAM = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    localparam int DEF_ADDR_W     = 16;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_NUM_GPR    = 32;
    localparam int DEF_IO_COUNT   = 64;
    localparam int DEF_SRAM_BYTES = 2048;
endpackage

// File: rtl/dspace_region_dec.sv
// Region decoder: classifies a byte address and produces region-local indices.
// Assumes IO_BASE < SRAM_BASE <= SRAM_LAST, all representable in ADDR_W bits.
module dspace_region_dec
    import dspace_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int IO_BASE    = 32,
    parameter int SRAM_BASE  = 96,
    parameter int SRAM_LAST  = 2143,
    parameter int GPR_IDX_W  = 5,
    parameter int IO_IDX_W   = 6,
    parameter int SRAM_IDX_W = 11
) (
    input  logic [ADDR_W-1:0]     addr,
    output region_e               rgn,
    output logic [GPR_IDX_W-1:0]  gpr_idx,
    output logic [IO_IDX_W-1:0]   io_idx,
    output logic [SRAM_IDX_W-1:0] sram_idx
);
    localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] SRAM_B = ADDR_W'(SRAM_BASE);
    localparam logic [ADDR_W-1:0] SRAM_L = ADDR_W'(SRAM_LAST);

    // Purpose: pick the region by comparing against the fixed boundaries.
    always_comb begin
        if (addr < IO_B)        rgn = RGN_GPR;
        else if (addr < SRAM_B) rgn = RGN_IO;
        else if (addr <= SRAM_L) rgn = RGN_SRAM;
        else                    rgn = RGN_NONE;
    end

    // Purpose: strip each region's base to get its local index.
    always_comb begin
        gpr_idx  = GPR_IDX_W'(addr);
        io_idx   = IO_IDX_W'(addr - IO_B);
        sram_idx = SRAM_IDX_W'(addr - SRAM_B);
    end
endmodule

// File: rtl/dspace_gpr_file.sv
// Register file with two write ports and two read ports.
// Port A (data space) has write priority over port B (ALU) on the same index.
// Reads are combinational; registers reset to zero.
module dspace_gpr_file #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [IDX_W-1:0]  a_widx,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [IDX_W-1:0]  b_widx,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [IDX_W-1:0]  a_ridx,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [IDX_W-1:0]  b_ridx,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Purpose: update one register, data-space port first.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (a_we && a_widx == IDX_W'(i))
                regs[i] <= a_wdata;
            else if (b_we && b_widx == IDX_W'(i))
                regs[i] <= b_wdata;
        end
    end

    // Purpose: combinational read ports.
    always_comb begin
        a_rdata = regs[a_ridx];
        b_rdata = regs[b_ridx];
    end
endmodule

// File: rtl/dspace_sram.sv
// Byte-wide SRAM model: synchronous write, combinational read, no reset.
// Assumes the caller only enables writes for in-range indices.
module dspace_sram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: commit a byte on the write edge.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Purpose: present the addressed byte.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/dspace_decoder.sv
// Top: routes data-space accesses to registers, external I/O or SRAM.
// Reads are registered (one cycle latency); read+write in a cycle is a write.
// Assumes io_rdata is valid combinationally while io_rd is high.
module dspace_decoder
    import dspace_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int NUM_GPR    = DEF_NUM_GPR,
    parameter int IO_COUNT   = DEF_IO_COUNT,
    parameter int SRAM_BYTES = DEF_SRAM_BYTES,
    localparam int GPR_IDX_W  = $clog2(NUM_GPR),
    localparam int IO_IDX_W   = $clog2(IO_COUNT),
    localparam int SRAM_IDX_W = $clog2(SRAM_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     ds_addr,
    input  logic                  ds_rd,
    input  logic                  ds_wr,
    input  logic [DATA_W-1:0]     ds_wdata,
    output logic [DATA_W-1:0]     ds_rdata,
    input  logic [GPR_IDX_W-1:0]  alu_raddr,
    output logic [DATA_W-1:0]     alu_rdata,
    input  logic                  alu_we,
    input  logic [GPR_IDX_W-1:0]  alu_waddr,
    input  logic [DATA_W-1:0]     alu_wdata,
    output logic [IO_IDX_W-1:0]   io_addr,
    output logic                  io_rd,
    output logic                  io_wr,
    output logic [DATA_W-1:0]     io_wdata,
    input  logic [DATA_W-1:0]     io_rdata
);
    localparam int IO_BASE   = NUM_GPR;
    localparam int SRAM_BASE = NUM_GPR + IO_COUNT;
    localparam int SRAM_LAST = SRAM_BASE + SRAM_BYTES - 1;

    region_e               rgn;
    logic [GPR_IDX_W-1:0]  gpr_idx;
    logic [SRAM_IDX_W-1:0] sram_idx;
    logic [DATA_W-1:0]     gpr_rdata;
    logic [DATA_W-1:0]     sram_rdata;
    logic [DATA_W-1:0]     rd_mux;
    logic                  rd_only;
    logic                  gpr_we;
    logic                  sram_we;

    dspace_region_dec #(
        .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .SRAM_BASE(SRAM_BASE),
        .SRAM_LAST(SRAM_LAST), .GPR_IDX_W(GPR_IDX_W),
        .IO_IDX_W(IO_IDX_W), .SRAM_IDX_W(SRAM_IDX_W)
    ) u_dec (
        .addr(ds_addr), .rgn(rgn), .gpr_idx(gpr_idx),
        .io_idx(io_addr), .sram_idx(sram_idx)
    );

    // Purpose: qualify strobes per region; a write masks a read.
    always_comb begin
        rd_only  = ds_rd && !ds_wr;
        gpr_we   = ds_wr && (rgn == RGN_GPR);
        sram_we  = ds_wr && (rgn == RGN_SRAM);
        io_wr    = ds_wr && (rgn == RGN_IO);
        io_rd    = rd_only && (rgn == RGN_IO);
        io_wdata = ds_wdata;
    end

    dspace_gpr_file #(.NUM_REGS(NUM_GPR), .DATA_W(DATA_W)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .a_we(gpr_we), .a_widx(gpr_idx), .a_wdata(ds_wdata),
        .b_we(alu_we), .b_widx(alu_waddr), .b_wdata(alu_wdata),
        .a_ridx(gpr_idx), .a_rdata(gpr_rdata),
        .b_ridx(alu_raddr), .b_rdata(alu_rdata)
    );

    dspace_sram #(.DEPTH(SRAM_BYTES), .DATA_W(DATA_W)) u_sram (
        .clk(clk), .we(sram_we), .idx(sram_idx),
        .wdata(ds_wdata), .rdata(sram_rdata)
    );

    // Purpose: select the read source; unmapped reads give zero.
    always_comb begin
        unique case (rgn)
            RGN_GPR:  rd_mux = gpr_rdata;
            RGN_IO:   rd_mux = io_rdata;
            RGN_SRAM: rd_mux = sram_rdata;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register read data on read-only cycles, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       ds_rdata <= '0;
        else if (rd_only) ds_rdata <= rd_mux;
    end
endmodule

// File: rtl/dspace_decoder_chk.sv
// Checker: port-level timing and routing properties of dspace_decoder.
// Assumes io_rdata is stable through each strobe cycle.
module dspace_decoder_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int IO_BASE   = 32,
    parameter int SRAM_BASE = 96,
    parameter int SRAM_LAST = 2143
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ds_addr,
    input logic              ds_rd,
    input logic              ds_wr,
    input logic [DATA_W-1:0] ds_rdata,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_rdata
);
    localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] SRAM_B = ADDR_W'(SRAM_BASE);
    localparam logic [ADDR_W-1:0] SRAM_L = ADDR_W'(SRAM_LAST);

    AST_IO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (ds_addr >= IO_B && ds_addr < SRAM_B)); // R5
    AST_IO_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> (ds_rdata == $past(io_rdata))); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_rd || ds_wr) |=> $stable(ds_rdata)); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_rd && !ds_wr && ds_addr > SRAM_L) |=> (ds_rdata == '0)); // R8
    AST_WRITE_MASKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_rd && ds_wr) |-> !io_rd); // R9
    AST_IO_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr})); // R9
endmodule

bind dspace_decoder dspace_decoder_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_BASE(IO_BASE),
    .SRAM_BASE(SRAM_BASE), .SRAM_LAST(SRAM_LAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ds_addr(ds_addr), .ds_rd(ds_rd),
    .ds_wr(ds_wr), .ds_rdata(ds_rdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata)
);

// File: tb/dspace_decoder_tb.sv
// Bench: behavioural reference model compared on every clock.
module dspace_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ds_addr;
    logic        ds_rd, ds_wr;
    logic [7:0]  ds_wdata, ds_rdata;
    logic [4:0]  alu_raddr, alu_waddr;
    logic [7:0]  alu_rdata, alu_wdata;
    logic        alu_we;
    logic [5:0]  io_addr;
    logic        io_rd, io_wr;
    logic [7:0]  io_wdata, io_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] gpr_m [32];
    logic [7:0] sram_m [int];
    logic [7:0] exp_rdata;

    always #5 clk = ~clk;

    function automatic logic [7:0] io_fn(input logic [5:0] a);
        return 8'(a * 7 + 8'h13);
    endfunction

    always_comb io_rdata = io_fn(io_addr);

    dspace_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ds_addr(ds_addr), .ds_rd(ds_rd),
        .ds_wr(ds_wr), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .alu_raddr(alu_raddr), .alu_rdata(alu_rdata), .alu_we(alu_we),
        .alu_waddr(alu_waddr), .alu_wdata(alu_wdata), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] lookup(input logic [15:0] a);
        if (a < 16'h20) return gpr_m[a[4:0]];
        if (a < 16'h60) return io_fn(6'(a - 16'h20));
        if (a <= 16'h85F) return sram_m.exists(int'(a)) ? sram_m[int'(a)] : 8'h00;
        return 8'h00;
    endfunction

    task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic awe, input logic [4:0] awa,
                       input logic [7:0] awd, input logic [4:0] ara);
        logic in_io;
        @(negedge clk);
        ds_addr = a; ds_rd = rd; ds_wr = wr; ds_wdata = wd;
        alu_we = awe; alu_waddr = awa; alu_wdata = awd; alu_raddr = ara;
        #1;
        in_io = (a >= 16'h20) && (a < 16'h60);
        check8("R5", {7'b0, io_rd}, {7'b0, rd && !wr && in_io});
        check8("R5", {7'b0, io_wr}, {7'b0, wr && in_io});
        if (in_io && (rd || wr)) check8("R5", {2'b0, io_addr}, 8'(a - 16'h20));
        if (in_io && wr) check8("R5", io_wdata, wd);
        // reference model: read first, then writes with data-space priority
        if (rd && !wr) exp_rdata = lookup(a);
        if (wr && a < 16'h20) gpr_m[a[4:0]] = wd;
        else if (wr && a >= 16'h60 && a <= 16'h85F) sram_m[int'(a)] = wd;
        if (awe && !(wr && a < 16'h20 && a[4:0] == awa)) gpr_m[awa] = awd;
        @(posedge clk);
        #1;
        check8("R2", ds_rdata, exp_rdata);
        check8("R11", alu_rdata, gpr_m[ara]);
    endtask

    task automatic idle(input logic [4:0] ara);
        cyc(16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 5'd0, 8'h00, ara);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) gpr_m[i] = 8'h00;
        exp_rdata = 8'h00;
        rst_n = 1'b0; ds_addr = '0; ds_rd = 0; ds_wr = 0; ds_wdata = '0;
        alu_we = 0; alu_waddr = '0; alu_wdata = '0; alu_raddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check8("R12", ds_rdata, 8'h00);
        for (int i = 0; i < 32; i++) begin
            idle(5'(i));
            check8("R12", alu_rdata, 8'h00);
        end

        // R3: register 0 via data address 0
        cyc(16'h0000, 0, 0, 8'h00, 1, 5'd0, 8'h5A, 5'd0);
        cyc(16'h0000, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R3", ds_rdata, 8'h5A);
        // R4: data-space write to top register, seen on ALU port
        cyc(16'h001F, 0, 1, 8'hC3, 0, 5'd0, 8'h00, 5'd31);
        check8("R4", alu_rdata, 8'hC3);
        // R10: collision, data space wins
        cyc(16'h0005, 0, 1, 8'h22, 1, 5'd5, 8'h11, 5'd5);
        check8("R10", alu_rdata, 8'h22);
        // R11: read in same cycle as ALU write returns old value
        cyc(16'h0005, 1, 0, 8'h00, 1, 5'd5, 8'h77, 5'd5);
        check8("R11", ds_rdata, 8'h22);
        check8("R11", alu_rdata, 8'h77);
        // R6: I/O reads at both window ends
        cyc(16'h0020, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R6", ds_rdata, io_fn(6'd0));
        cyc(16'h005F, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R6", ds_rdata, io_fn(6'd63));
        cyc(16'h003B, 0, 1, 8'h9E, 0, 5'd0, 8'h00, 5'd0);
        // R7: SRAM ends and windows used by random traffic
        for (int i = 0; i < 16; i++) begin
            cyc(16'(16'h60 + i), 0, 1, 8'(i * 13 + 1), 0, 5'd0, 8'h00, 5'd0);
            cyc(16'(16'h850 + i), 0, 1, 8'(i * 29 + 4), 0, 5'd0, 8'h00, 5'd0);
        end
        cyc(16'h0060, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R7", ds_rdata, 8'h01);
        cyc(16'h085F, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R7", ds_rdata, 8'(15 * 29 + 4));
        // R8: unmapped write ignored, unmapped reads zero
        cyc(16'h0860, 0, 1, 8'hEE, 0, 5'd0, 8'h00, 5'd0);
        cyc(16'h0860, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R8", ds_rdata, 8'h00);
        cyc(16'h0060, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R8", ds_rdata, 8'h01);
        cyc(16'hFFFF, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R8", ds_rdata, 8'h00);
        // R9: overlapping strobes write only
        cyc(16'h0020, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        cyc(16'h0061, 1, 1, 8'hA7, 0, 5'd0, 8'h00, 5'd0);
        check8("R9", ds_rdata, io_fn(6'd0));
        cyc(16'h0061, 1, 0, 8'h00, 0, 5'd0, 8'h00, 5'd0);
        check8("R9", ds_rdata, 8'hA7);
        // R2: idle cycles hold
        idle(5'd0);
        check8("R2", ds_rdata, 8'hA7);

        // R1: random traffic across all regions
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            int kind;
            kind = int'($urandom_range(0, 4));
            case (kind)
                0: a = 16'($urandom_range(0, 31));
                1: a = 16'($urandom_range(32, 95));
                2: a = 16'($urandom_range(16'h60, 16'h6F));
                3: a = 16'($urandom_range(16'h850, 16'h85F));
                default: a = 16'($urandom_range(16'h860, 16'hFFFF));
            endcase
            cyc(a, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
                5'($urandom), 8'($urandom), 5'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule